// File: doc/BRIEF.md
# Block Boundary Flywheel with Per-Block Status

This block follows block boundaries in a stream of 16-bit words. Each nominal block is 1176 words long. A word strobe marks every valid word. On the strobe that carries a word, a sync-detected pulse may say that the word closes a block, and an erasure flag may say that the word's bytes were marked unreliable upstream. A word counter runs as a flywheel. It expects the closing sync on position 1175. It inserts that sync itself when none arrives, or it lets the block run long when insertion is switched off. When retiming is enabled, an early sync restarts it.

Each accepted or inserted sync produces a one-clock block-start pulse. Anomalies seen during a block gather in a pending set. At the block start they are copied into a status register that a CPU-style read port returns, and the pending set is cleared for the next block. Downstream correction logic uses the status to hold off on blocks whose data is misaligned.

Top module: `sfw_flywheel`

## Requirements
- R1: Reset clears the status register and the read data. The counter restarts at position 0 and no block-start pulse is driven.
- R2: A sync on a strobed word at position 1175 gives `blk_start_o` high for one clock in the cycle after that strobe edge. The counter then restarts at 0 and the misplaced bit stays clear for that event.
- R3: If the counter sits at position 1175 with no sync while `ins_en_i` is 1, a sync is inserted there. The pulse follows as in R2 and status bit 3 (inserted) is set.
- R4: If the counter sits at position 1175 with no sync while `ins_en_i` is 0, no pulse is given. The counter runs on past 1175 (saturating at its maximum) and status bit 2 (extended) is set. Bits 2 and 3 are never both set.
- R5: A sync at positions 0 to 1174 while `retime_en_i` is 1 retimes the counter and gives a pulse. It sets status bit 4 (misplaced) and bit 1 (short block); bit 1 is only ever set together with bit 4.
- R6: A sync at positions 0 to 1174 while `retime_en_i` is 0 is ignored. It gives no pulse, sets no flag and leaves the counter running, so the block still ends at position 1175.
- R7: A sync at a position above 1175, which can only happen when the block is extended, always ends the block with a pulse and sets status bit 4 (misplaced).
- R8: An erasure on any strobed word of a block sets status bit 0 (erasures) for that block, including the word that closes it.
- R9: Flags are collected per block and copied into the status register only at a block start, then cleared. The status register changes at no other time.
- R10: When `rd_en_i` is high at a clock edge, `rd_data_o` takes the status register value before that edge, with bits 7:5 zero. Otherwise it holds its value.
- R11: With `word_i` low, `sync_i` and `erasure_i` have no effect. The counter holds and no pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 1 | Word strobe, one per valid word |
| sync_i | input | 1 | Sync detected on the strobed word |
| erasure_i | input | 1 | Strobed word carries an erasure |
| ins_en_i | input | 1 | Enable sync insertion at position 1175 |
| retime_en_i | input | 1 | Enable retiming on early syncs |
| rd_en_i | input | 1 | Read strobe for the status register |
| blk_start_o | output | 1 | One-clock block-start pulse |
| rd_data_o | output | 8 | Status read data (bit4 misplaced, bit3 inserted, bit2 extended, bit1 short, bit0 erasures) |

## Verification
The bench closes blocks exactly at position 1175, at random early positions, and late after an extension, under all four enable settings. A design that mis-compares against the last position would pulse one word early or late, or flag nominal blocks as misplaced. Early syncs with retiming off are the key trap: a design that still retimes, or that records a short block, ends the block too soon or reports a false flag. Erasures on the closing word, and syncs or erasures on non-strobed cycles, catch a design that credits flags to the wrong block or samples inputs without the strobe.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    // Per-block anomaly set; packed order fixes the read-port bit layout.
    typedef struct packed {
        logic misplaced;  // bit 4
        logic inserted;   // bit 3
        logic extended;   // bit 2
        logic short_blk;  // bit 1
        logic erasure;    // bit 0
    } sfw_flags_t;

    localparam int FLAGS_W = $bits(sfw_flags_t);
    localparam int RD_W    = 8;

endpackage

// File: rtl/sfw_word_counter.sv
module sfw_word_counter
    import sfw_pkg::*;
#(
    parameter int BLOCK_WORDS = 1176,
    parameter int CNT_W       = $clog2(BLOCK_WORDS) + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             word_i,
    input  logic             sync_i,
    input  logic             ins_en_i,
    input  logic             retime_en_i,
    output logic             start_o,
    output sfw_flags_t       ev_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(BLOCK_WORDS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       start_d;
    sfw_flags_t ev_d;

    always_comb begin
        st_d    = st_q;
        start_d = 1'b0;
        ev_d    = '0;
        if (word_i) begin
            if (st_q.cnt == LAST_POS) begin
                if (sync_i) begin
                    start_d = 1'b1;
                end else if (ins_en_i) begin
                    start_d     = 1'b1;
                    ev_d.inserted = 1'b1;
                end else begin
                    ev_d.extended = 1'b1;
                end
            end else if (st_q.cnt < LAST_POS) begin
                if (sync_i && retime_en_i) begin
                    start_d        = 1'b1;
                    ev_d.misplaced = 1'b1;
                    ev_d.short_blk = 1'b1;
                end
            end else if (sync_i) begin
                start_d        = 1'b1;
                ev_d.misplaced = 1'b1;
            end

            if (start_d) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = start_d;
    assign ev_o    = ev_d;
    assign cnt_o   = st_q.cnt;

endmodule

// File: rtl/sfw_flag_accum.sv
module sfw_flag_accum
    import sfw_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       word_i,
    input  logic       erasure_i,
    input  logic       start_i,
    input  sfw_flags_t ev_i,
    output sfw_flags_t status_o
);

    typedef struct packed {
        sfw_flags_t pend;
        sfw_flags_t status;
    } acc_state_t;

    acc_state_t st_d, st_q;
    sfw_flags_t merged;

    always_comb begin
        st_d   = st_q;
        merged = st_q.pend | ev_i;
        merged.erasure = merged.erasure | erasure_i;
        if (word_i) begin
            if (start_i) begin
                st_d.status = merged;
                st_d.pend   = '0;
            end else begin
                st_d.pend = merged;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;

endmodule

// File: rtl/sfw_read_port.sv
module sfw_read_port
    import sfw_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            rd_en_i,
    input  sfw_flags_t      status_i,
    output logic [RD_W-1:0] rd_data_o
);

    localparam int PAD_W = RD_W - FLAGS_W;

    typedef struct packed {
        logic [RD_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en_i) begin
            st_d.data = {{PAD_W{1'b0}}, status_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.data;

endmodule

// File: rtl/sfw_flywheel.sv
module sfw_flywheel
    import sfw_pkg::*;
#(
    parameter int BLOCK_WORDS = 1176
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       word_i,
    input  logic       sync_i,
    input  logic       erasure_i,
    input  logic       ins_en_i,
    input  logic       retime_en_i,
    input  logic       rd_en_i,
    output logic       blk_start_o,
    output logic [7:0] rd_data_o
);

    localparam int CNT_W = $clog2(BLOCK_WORDS) + 1;

    typedef struct packed {
        logic blk_start;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic             start_now;
    sfw_flags_t       ev_now;
    sfw_flags_t       status;
    logic [CNT_W-1:0] word_cnt;

    sfw_word_counter #(
        .BLOCK_WORDS (BLOCK_WORDS),
        .CNT_W       (CNT_W)
    ) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .word_i      (word_i),
        .sync_i      (sync_i),
        .ins_en_i    (ins_en_i),
        .retime_en_i (retime_en_i),
        .start_o     (start_now),
        .ev_o        (ev_now),
        .cnt_o       (word_cnt)
    );

    sfw_flag_accum u_acc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .word_i    (word_i),
        .erasure_i (erasure_i),
        .start_i   (start_now),
        .ev_i      (ev_now),
        .status_o  (status)
    );

    sfw_read_port u_rd (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_en_i   (rd_en_i),
        .status_i  (status),
        .rd_data_o (rd_data_o)
    );

    always_comb begin
        st_d           = st_q;
        st_d.blk_start = start_now;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blk_start_o = st_q.blk_start;

endmodule

// File: rtl/sfw_flywheel_chk.sv
module sfw_flywheel_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             word_i,
    input logic             rd_en_i,
    input logic             blk_start_o,
    input logic [7:0]       rd_data_o,
    input logic [CNT_W-1:0] cnt,
    input logic [4:0]       status
);

    // Counter is back at zero whenever the start pulse is out
    assert_restart_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blk_start_o |-> (cnt == '0));

    // No strobe, no movement and no pulse
    assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(word_i) |-> ($stable(cnt) && !blk_start_o));

    // Status only changes together with a block start
    assert_status_at_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(status) |-> blk_start_o);

    // Extension and insertion exclude each other within one block
    assert_ext_not_ins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status[2] |-> !status[3]);

    // A short block is always a misplaced one
    assert_short_misplaced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status[1] |-> status[4]);

    // Read data follows the status one edge after the read strobe
    assert_read_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rd_en_i) |-> (rd_data_o == {3'b000, $past(status)}));

endmodule

bind sfw_flywheel sfw_flywheel_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_i      (word_i),
    .rd_en_i     (rd_en_i),
    .blk_start_o (blk_start_o),
    .rd_data_o   (rd_data_o),
    .cnt         (word_cnt),
    .status      (status)
);

// File: tb/sfw_flywheel_tb.sv
module sfw_flywheel_tb;

    localparam int BLOCK_WORDS = 1176;
    localparam int LAST        = BLOCK_WORDS - 1;
    localparam int CNT_MAX     = (1 << ($clog2(BLOCK_WORDS) + 1)) - 1;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       word_i = 1'b0;
    logic       sync_i = 1'b0;
    logic       erasure_i = 1'b0;
    logic       ins_en_i = 1'b0;
    logic       retime_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic       blk_start_o;
    logic [7:0] rd_data_o;

    int checks = 0;
    int errors = 0;

    // reference model state
    int         m_cnt = 0;
    logic [4:0] m_pend = '0;
    logic [4:0] m_status = '0;
    logic [7:0] exp_rd = '0;
    logic       exp_start = 1'b0;
    string      m_tag = "R1";

    always #10 clk_i = ~clk_i;

    sfw_flywheel #(.BLOCK_WORDS(BLOCK_WORDS)) u_dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .word_i      (word_i),
        .sync_i      (sync_i),
        .erasure_i   (erasure_i),
        .ins_en_i    (ins_en_i),
        .retime_en_i (retime_en_i),
        .rd_en_i     (rd_en_i),
        .blk_start_o (blk_start_o),
        .rd_data_o   (rd_data_o)
    );

    function automatic string bit_tag(input logic [7:0] diff);
        if (diff[0]) return "R8";
        if (diff[1]) return "R5";
        if (diff[2]) return "R4";
        if (diff[3]) return "R3";
        if (diff[4]) return "R7";
        return "R10";
    endfunction

    task automatic check_outputs();
        checks++;
        if (blk_start_o !== exp_start) begin
            errors++;
            $display("FAIL %s blk_start actual %0b expected %0b (pos model %0d)",
                     m_tag, blk_start_o, exp_start, m_cnt);
        end
        checks++;
        if (rd_data_o !== exp_rd) begin
            errors++;
            $display("FAIL %s rd_data actual %02h expected %02h",
                     bit_tag(rd_data_o ^ exp_rd), rd_data_o, exp_rd);
        end
    endtask

    task automatic model(input logic w, input logic s, input logic e,
                         input logic ins, input logic ret, input logic rd);
        logic [4:0] acc;
        logic [4:0] old;
        logic       st;
        old = m_status;
        st  = 1'b0;
        m_tag = "R11";
        if (w) begin
            acc = m_pend;
            if (e) acc[0] = 1'b1;
            if (m_cnt == LAST) begin
                if (s) begin
                    st = 1'b1; m_tag = "R2";
                end else if (ins) begin
                    st = 1'b1; acc[3] = 1'b1; m_tag = "R3";
                end else begin
                    acc[2] = 1'b1; m_tag = "R4";
                end
            end else if (m_cnt < LAST) begin
                if (s && ret) begin
                    st = 1'b1; acc[4] = 1'b1; acc[1] = 1'b1; m_tag = "R5";
                end else begin
                    m_tag = s ? "R6" : "R2";
                end
            end else begin
                if (s) begin
                    st = 1'b1; acc[4] = 1'b1; m_tag = "R7";
                end else begin
                    m_tag = "R4";
                end
            end
            if (st) begin
                m_status = acc;
                m_pend   = '0;
                m_cnt    = 0;
            end else begin
                m_pend = acc;
                if (m_cnt < CNT_MAX) m_cnt++;
            end
        end
        exp_start = st;
        if (rd) exp_rd = {3'b000, old};
    endtask

    task automatic step(input logic w, input logic s, input logic e,
                        input logic ins, input logic ret, input logic rd);
        word_i = w; sync_i = s; erasure_i = e;
        ins_en_i = ins; retime_en_i = ret; rd_en_i = rd;
        model(w, s, e, ins, ret, rd);
        @(posedge clk_i);
        @(negedge clk_i);
        check_outputs();
    endtask

    // kind 0: sync on 1175; 1: early sync then 1175; 2: no sync until late
    task automatic run_block(input logic ins, input logic ret, input int kind);
        int tgt;
        int tgt2;
        int eras_pos;
        logic w;
        logic s;
        logic e;
        tgt = -1;
        tgt2 = -1;
        if (kind == 0) tgt = LAST;
        else if (kind == 1) begin
            tgt = int'($urandom % LAST);
            tgt2 = LAST;
        end else tgt2 = LAST + 1 + int'($urandom % 40);
        eras_pos = ($urandom % 2 == 0) ? int'($urandom % BLOCK_WORDS) : -1;
        for (int n = 0; n < 1800; n++) begin
            w = ($urandom % 8) != 0;
            if (w) begin
                s = (m_cnt == tgt) || (m_cnt == tgt2);
                e = (m_cnt == eras_pos);
            end else begin
                s = ($urandom % 16) == 0;
                e = ($urandom % 16) == 0;
            end
            step(w, s, e, ins, ret, 1'($urandom % 2));
            if (exp_start) break;
        end
        step(1'b0, 1'b0, 1'b0, ins, ret, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd7391));
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        // R1: reset state
        checks++;
        if (blk_start_o !== 1'b0 || rd_data_o !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset outputs actual %0b/%02h expected 0/00", blk_start_o, rd_data_o);
        end
        rst_ni = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);

        // R5: sync on the very first word with retiming on
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        checks++;
        if (rd_data_o !== 8'h12) begin
            errors++;
            $display("FAIL R5 early-sync status actual %02h expected 12", rd_data_o);
        end

        // R8: erasure on the closing word of a nominal block
        for (int i = 0; i < LAST; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        checks++;
        if (rd_data_o !== 8'h01) begin
            errors++;
            $display("FAIL R8 closing-word erasure actual %02h expected 01", rd_data_o);
        end

        // all enable combinations, all block kinds
        for (int c = 0; c < 4; c++) begin
            for (int b = 0; b < 6; b++) begin
                run_block(1'(c >> 1), 1'(c & 1), b % 3);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog expired (R2 progress) actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule